// File: doc/BRIEF.md
# Memory error record logger

This block sits behind a memory test engine and condenses its stream of data mismatches into compact error records. Each incoming event carries the test number, the address that failed, the data that was written and the data that was read back. The block derives the failing-bit mask as the XOR of the two data words and holds one open record at a time. Further events that hit the same address with the same failing bits do not make new records; they only raise the repeat count of the open record.

When an event arrives whose address or mask differs, the open record is closed and pushed into a four-entry output queue, and the new event opens the next record. A flush pulse at the end of a test closes the open record in the same way. Closed records leave through a valid/ready port. If the consumer holds off and the queue is full, the block drops its event-ready signal only for events that would need a push, so the test engine stalls instead of losing records.

Top module: `err_rec_logger`

## Requirements
- R1: A record carries the test number, address, expected data and observed data of the first event of its run; later merged events do not change these fields.
- R2: The record mask equals expected XOR observed data, so every presented record satisfies mask == exp ^ obs.
- R3: An accepted event whose address and mask both equal those of the open record emits nothing; an accepted event that differs in either pushes the open record and opens a new one.
- R4: The repeat count equals the number of consecutive merged events, the first event counting as 1.
- R5: The repeat count saturates at 2^CNT_W-1 (15 by default) and never wraps.
- R6: Records leave in the order they were closed; while rec_valid is high and rec_ready low, the presented record stays unchanged.
- R7: With DEPTH (4) records queued, ev_ready is low for an event that differs from the open record, and high for an event that matches it.
- R8: A flush pulse pushes the open record, waiting while the queue is full; ev_ready is low during the flush pulse and while it is pending; a flush with no open record emits nothing.
- R9: Synchronous active-high reset empties the queue and discards the open record: after reset rec_valid is low, ev_ready is high and a flush emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_test | input | TEST_W | Test number of the event |
| ev_addr | input | ADDR_W | Failing address |
| ev_exp | input | DATA_W | Expected data |
| ev_obs | input | DATA_W | Observed data |
| flush | input | 1 | Close the open record |
| rec_valid | output | 1 | Record presented |
| rec_ready | input | 1 | Consumer takes the record |
| rec_test | output | TEST_W | Record test number |
| rec_addr | output | ADDR_W | Record address |
| rec_exp | output | DATA_W | Record expected data |
| rec_obs | output | DATA_W | Record observed data |
| rec_mask | output | DATA_W | Failing-bit mask |
| rec_count | output | CNT_W | Repeat count |

## Verification
Two collisions are provoked on purpose. A flush pulse is raised in the same cycle as a pending event, and the bench requires ev_ready low in that cycle and then the event to open a fresh record rather than join the flushed one. With the queue full, a matching event must still be taken and merged while a differing one is held; the bench judges both through ev_ready, the stable head record and the counts of the records drained afterwards.

// File: rtl/err_rec_pkg.sv
package err_rec_pkg;
    parameter int TEST_W = 4;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int CNT_W  = 4;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp;
        logic [DATA_W-1:0] obs;
        logic [DATA_W-1:0] mask;
        logic [CNT_W-1:0]  count;
    } err_rec_t;
endpackage

// File: rtl/err_rec_merge.sv
module err_rec_merge
    import err_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid_i,
    input  logic [TEST_W-1:0] ev_test_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [DATA_W-1:0] ev_exp_i,
    input  logic [DATA_W-1:0] ev_obs_i,
    input  logic              flush_i,
    input  logic              fifo_full_i,
    output logic              ev_ready_o,
    output logic              push_o,
    output err_rec_t          push_rec_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic     open;
        logic     flush_pend;
        err_rec_t rec;
    } mrg_st_t;

    mrg_st_t  st_q, st_d;
    err_rec_t new_rec;
    logic     same, flush_req, need_push, fire;

    always_comb begin
        new_rec.test  = ev_test_i;
        new_rec.addr  = ev_addr_i;
        new_rec.exp   = ev_exp_i;
        new_rec.obs   = ev_obs_i;
        new_rec.mask  = ev_exp_i ^ ev_obs_i;
        new_rec.count = {{(CNT_W-1){1'b0}}, 1'b1};

        same      = st_q.open && (ev_addr_i == st_q.rec.addr) && (new_rec.mask == st_q.rec.mask);
        flush_req = flush_i || st_q.flush_pend;
        need_push = st_q.open && !same;
        ev_ready_o = !flush_req && !(need_push && fifo_full_i);
        fire      = ev_valid_i && ev_ready_o;

        st_d       = st_q;
        push_o     = 1'b0;
        push_rec_o = st_q.rec;

        if (flush_req) begin
            if (st_q.open) begin
                if (!fifo_full_i) begin
                    push_o          = 1'b1;
                    st_d.open       = 1'b0;
                    st_d.flush_pend = 1'b0;
                end else begin
                    st_d.flush_pend = 1'b1;
                end
            end else begin
                st_d.flush_pend = 1'b0;
            end
        end else if (fire) begin
            if (same) begin
                if (st_q.rec.count != CNT_MAX)
                    st_d.rec.count = st_q.rec.count + 1'b1;
            end else begin
                push_o    = need_push;
                st_d.rec  = new_rec;
                st_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_READY_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_i |-> !ev_ready_o); // R8
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.open |-> (st_q.rec.count != '0)); // R4
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.open && st_q.rec.count == CNT_MAX && !push_o) |=> (st_q.rec.count == CNT_MAX)); // R5
endmodule

// File: rtl/err_rec_fifo.sv
module err_rec_fifo
    import err_rec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push_i,
    input  err_rec_t push_rec_i,
    input  logic     pop_i,
    output err_rec_t head_o,
    output logic     valid_o,
    output logic     full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    typedef struct packed {
        err_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wr;
        logic [PTR_W-1:0]     rd;
        logic [LVL_W-1:0]     lvl;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     do_push, do_pop;

    always_comb begin
        valid_o = (st_q.lvl != '0);
        full_o  = (st_q.lvl == LVL_FULL);
        head_o  = st_q.mem[st_q.rd];
        do_push = push_i && !full_o;
        do_pop  = pop_i && valid_o;

        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_rec_i;
            st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop)
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
        if (do_push && !do_pop)      st_d.lvl = st_q.lvl + 1'b1;
        else if (do_pop && !do_push) st_d.lvl = st_q.lvl - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o); // R7
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !pop_i) |=> (valid_o && $stable(head_o))); // R6
endmodule

// File: rtl/err_rec_logger.sv
module err_rec_logger
    import err_rec_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [TEST_W-1:0] ev_test,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_exp,
    input  logic [DATA_W-1:0] ev_obs,
    input  logic              flush,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [TEST_W-1:0] rec_test,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_exp,
    output logic [DATA_W-1:0] rec_obs,
    output logic [DATA_W-1:0] rec_mask,
    output logic [CNT_W-1:0]  rec_count
);
    logic     push, full;
    err_rec_t push_rec, head;

    err_rec_merge u_merge (
        .clk(clk), .rst(rst),
        .ev_valid_i(ev_valid), .ev_test_i(ev_test), .ev_addr_i(ev_addr),
        .ev_exp_i(ev_exp), .ev_obs_i(ev_obs), .flush_i(flush),
        .fifo_full_i(full), .ev_ready_o(ev_ready),
        .push_o(push), .push_rec_o(push_rec)
    );

    err_rec_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push_i(push), .push_rec_i(push_rec),
        .pop_i(rec_valid && rec_ready),
        .head_o(head), .valid_o(rec_valid), .full_o(full)
    );

    assign rec_test  = head.test;
    assign rec_addr  = head.addr;
    assign rec_exp   = head.exp;
    assign rec_obs   = head.obs;
    assign rec_mask  = head.mask;
    assign rec_count = head.count;

    AST_MASK_XOR: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_mask == (rec_exp ^ rec_obs))); // R2
endmodule

// File: tb/err_rec_logger_test.sv
`timescale 1ns/1ps
module err_rec_logger_test;
    import err_rec_pkg::*;

    logic clk = 0, rst = 1;
    logic ev_valid = 0, flush = 0, rec_ready = 0;
    logic [TEST_W-1:0] ev_test = 0;
    logic [ADDR_W-1:0] ev_addr = 0;
    logic [DATA_W-1:0] ev_exp = 0, ev_obs = 0;
    logic ev_ready, rec_valid;
    logic [TEST_W-1:0] rec_test;
    logic [ADDR_W-1:0] rec_addr;
    logic [DATA_W-1:0] rec_exp, rec_obs, rec_mask;
    logic [CNT_W-1:0]  rec_count;

    int total = 0, bad = 0;
    err_rec_t expq[$];
    err_rec_t mrec;
    logic mopen = 0;

    always #4 clk = ~clk;

    err_rec_logger #(.DEPTH(4)) uut (.*);

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic model_accept(input int t, input int a, input int e, input int o);
        logic [DATA_W-1:0] m;
        m = DATA_W'(e ^ o);
        if (mopen && ADDR_W'(a) == mrec.addr && m == mrec.mask) begin
            if (mrec.count != {CNT_W{1'b1}}) mrec.count++;
        end else begin
            if (mopen) expq.push_back(mrec);
            mrec = '{TEST_W'(t), ADDR_W'(a), DATA_W'(e), DATA_W'(o), m, CNT_W'(1)};
            mopen = 1;
        end
    endtask

    task automatic send(input int t, input int a, input int e, input int o);
        @(negedge clk);
        ev_valid = 1; ev_test = TEST_W'(t); ev_addr = ADDR_W'(a);
        ev_exp = DATA_W'(e); ev_obs = DATA_W'(o);
        #1;
        while (!ev_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        model_accept(t, a, e, o);
        @(negedge clk);
        ev_valid = 0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1;
        @(posedge clk);
        if (mopen) expq.push_back(mrec);
        mopen = 0;
        @(negedge clk); flush = 0;
    endtask

    task automatic drain();
        @(negedge clk); rec_ready = 1;
        for (int i = 0; i < 60 && (expq.size() != 0 || rec_valid); i++) @(negedge clk);
        #2;
        check(expq.size() == 0, "R6 all expected records drained", expq.size(), 0);
        check(!rec_valid, "R3 no extra record", rec_valid, 0);
    endtask

    // collector: compares every record the consumer takes
    initial forever begin
        err_rec_t e;
        @(negedge clk); #1;
        if (!rst && rec_valid && rec_ready) begin
            if (expq.size() == 0) begin
                check(0, "R3 unexpected record", rec_addr, 0);
            end else begin
                e = expq.pop_front();
                check(rec_test == e.test, "R1 test", rec_test, e.test);
                check(rec_addr == e.addr, "R6 order/addr", rec_addr, e.addr);
                check(rec_exp == e.exp && rec_obs == e.obs, "R1 data", {rec_exp, rec_obs}, {e.exp, e.obs});
                check(rec_mask == e.mask, "R2 mask", rec_mask, e.mask);
                check(rec_count == e.count, "R4 R5 count", rec_count, e.count);
            end
        end
    end

    initial begin
        #(8 * 20000);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(!rec_valid, "R9 reset rec_valid", rec_valid, 0);
        check(ev_ready, "R9 reset ev_ready", ev_ready, 1);

        // run-length sweep: counts 1..17, saturating at 15
        rec_ready = 1;
        for (int n = 1; n <= 17; n++)
            for (int k = 0; k < n; k++) send(n[3:0], 'h200 + n, 'hA5, 'hA5 ^ n);
        do_flush();
        drain();

        // mask sweep at one address: every single-bit mask is a new record
        for (int b = 0; b < DATA_W; b++) begin
            send(2, 'h300, 'hFF, 'hFF ^ (1 << b));
            send(2, 'h300, 'hFF, 'hFF ^ (1 << b));
        end
        // same mask, other data: merges, keeps first data (R1)
        send(3, 'h310, 'h0F, 'h0E);
        send(4, 'h310, 'hF1, 'hF0);
        do_flush();
        drain();

        // stall: fill the queue with rec_ready low
        @(negedge clk); rec_ready = 0;
        for (int i = 0; i < 5; i++) send(5, 'h100 + i, 0, 1 << i);
        #1;
        check(rec_valid && rec_addr == 'h100, "R6 head while stalled", rec_addr, 'h100);
        send(5, 'h104, 0, 1 << 4); // matching event accepted while full
        @(negedge clk);
        ev_valid = 1; ev_test = 6; ev_addr = 'h1F0; ev_exp = 0; ev_obs = 'h80;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!ev_ready, "R7 differing event stalled when full", ev_ready, 0);
            check(rec_addr == 'h100, "R6 head held", rec_addr, 'h100);
            @(negedge clk);
        end
        ev_valid = 0;
        @(negedge clk); rec_ready = 1;
        send(6, 'h1F0, 0, 'h80);

        // flush collides with a pending event
        @(negedge clk);
        flush = 1; ev_valid = 1; ev_test = 7; ev_addr = 'h1F0; ev_exp = 0; ev_obs = 'h80;
        #1;
        check(!ev_ready, "R8 ev_ready low during flush", ev_ready, 0);
        @(posedge clk);
        if (mopen) expq.push_back(mrec);
        mopen = 0;
        @(negedge clk); flush = 0; #1;
        while (!ev_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        model_accept(7, 'h1F0, 0, 'h80);
        @(negedge clk); ev_valid = 0;
        do_flush();
        drain();

        // flush with nothing open
        do_flush();
        repeat (3) @(negedge clk);
        #1;
        check(!rec_valid, "R8 empty flush emits nothing", rec_valid, 0);

        // reset mid-stream
        @(negedge clk); rec_ready = 0;
        for (int i = 0; i < 3; i++) send(8, 'h400 + i, 0, 3);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expq.delete(); mopen = 0;
        #1;
        check(!rec_valid, "R9 queue cleared", rec_valid, 0);
        check(ev_ready, "R9 ready after reset", ev_ready, 1);
        do_flush();
        repeat (3) @(negedge clk);
        #1;
        check(!rec_valid, "R9 open record discarded", rec_valid, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule